// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the configuration-address register of a host bridge. The processor writes a word in which the target device is picked by a single set bit somewhere in bits 11 to 31, the line that would drive that device's select input. The block does not keep that word as written. It turns it into a conventional configuration address, with an enable bit, a bus-encoding bit, a 5-bit device number and the function and register fields, and holds the result. When the processor reads the register back, the block rebuilds the one-hot form from the stored address. The stored address leaves the block on a port for the decoder of the configuration data window.

A build-time mode selects a second, simpler variant. In that variant the written word is stored almost verbatim. Only the enable flag moves between bit 31 of the stored address and bit 0 of the processor's view. A second build-time option swaps all four byte lanes in both directions, for a big-endian processor. The register bus is plain and 32 bits wide. Byte, halfword and word accesses all act as one full-word access. The register answers only inside its own word of the address map.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset `cfg_addr_o` is 0x00000000. A read of the register then returns 0x00000001 in both modes, or 0x01000000 when the byte swap is on.
- R2: The register is selected when `reg_addr_i[ADDR_W-1:2]` equals the base word index. Bits 1:0 of the address do not matter. When the register is not selected, `reg_rdata_o` is 0.
- R3: In main mode a write sets `cfg_addr_o[15:11]` to the index of the lowest set bit among bits 11..31 of the written word. If none of those bits is set, the field is 0, which is the low five bits of 32.
- R4: In main mode a write stores 1 in bit 31 and copies bits 10:2 of the written word. It stores 0 in bits 30:17 and bits 1:0.
- R5: In main mode a write sets stored bit 16 to bit 0 of the written word.
- R6: In main mode a read returns the OR of three terms: a one-hot bit at position `cfg_addr_o[15:11]`, `cfg_addr_o[10:8]` at bits 10:8, and `cfg_addr_o[7:2]` at bits 7:2. For any word with a single set bit at position 11..31, any value in bits 10:2 and bits 1:0 clear, a write followed by a read returns that same word.
- R7: In simple mode a write stores the written word with bit 0 cleared and bit 31 set.
- R8: In simple mode a read returns the stored word with bit 0 set and bit 31 cleared.
- R9: With the byte swap on, the written word is byte-reversed before it is translated, and the read result is byte-reversed after it is built.
- R10: A read in the same cycle as a write returns the value from before the write. The new stored address appears on `cfg_addr_o` one clock after the write strobe.
- R11: A write strobe while the register is not selected leaves `cfg_addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W | Register bus byte address |
| reg_wdata_i | input | 32 | Register bus write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Read data, combinational from address and stored value |
| cfg_addr_o | output | 32 | Stored configuration address for the data-window decoder |

## Verification
A write and a read of the register can fall in the same cycle, because read data is combinational and is valid whenever the register is addressed. Every write in the bench is therefore also a read of the old value. A dedicated pair of back-to-back writes makes the overlap explicit. The scoreboard expects the pre-write translation on `reg_rdata_o` during the strobe cycle and the new address on `cfg_addr_o` one cycle later. Three instances, one per variant, share a single bus, so the same overlap is judged at once in main, simple and byte-swapped form.

// File: rtl/cax_pkg.sv
package cax_pkg;
    typedef logic [31:0] cax_word_t;

    localparam int unsigned EN_BIT     = 31;
    localparam int unsigned BUSSEL_BIT = 16;
    localparam int unsigned DEV_LSB    = 11;
    localparam int unsigned DEV_W      = 5;
    localparam int unsigned SCAN_LO    = 11;
    localparam int unsigned SCAN_HI    = 31;
    localparam cax_word_t   REGNO_MASK = 32'h0000_07FC;
    localparam cax_word_t   LOWREG_MSK = 32'h0000_00FC;

    function automatic cax_word_t lane_reverse(input cax_word_t w);
        cax_word_t r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = w[8*(3-b) +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/cax_lane_swap.sv
module cax_lane_swap
    import cax_pkg::*;
#(
    parameter bit SWAP = 1'b0
) (
    input  cax_word_t word_i,
    output cax_word_t word_o
);
    generate
        if (SWAP) begin : g_swap
            assign word_o = lane_reverse(word_i);
        end else begin : g_pass
            assign word_o = word_i;
        end
    endgenerate
endmodule

// File: rtl/cax_wr_xlate.sv
module cax_wr_xlate
    import cax_pkg::*;
#(
    parameter bit MAIN_MODE = 1'b1
) (
    input  cax_word_t word_i,
    output cax_word_t cfg_o
);
    generate
        if (MAIN_MODE) begin : g_main
            logic [5:0]       first_idx;
            logic [DEV_W-1:0] dev_num;
            logic             unused_w1;

            // Priority scan: lowest set select bit wins; 32 when none set.
            always_comb begin
                first_idx = 6'd32;
                for (int b = SCAN_HI; b >= SCAN_LO; b--) begin
                    if (word_i[b]) first_idx = 6'(b);
                end
            end

            assign dev_num   = first_idx[DEV_W-1:0];
            assign unused_w1 = word_i[1];

            always_comb begin
                cfg_o                         = '0;
                cfg_o[EN_BIT]                 = 1'b1;
                cfg_o[BUSSEL_BIT]             = word_i[0];
                cfg_o[DEV_LSB +: DEV_W]       = dev_num;
                cfg_o                         = cfg_o | (word_i & REGNO_MASK);
            end
        end else begin : g_simple
            always_comb begin
                cfg_o         = word_i;
                cfg_o[0]      = 1'b0;
                cfg_o[EN_BIT] = 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/cax_rd_xlate.sv
module cax_rd_xlate
    import cax_pkg::*;
#(
    parameter bit MAIN_MODE = 1'b1
) (
    input  cax_word_t cfg_i,
    output cax_word_t word_o
);
    generate
        if (MAIN_MODE) begin : g_main
            logic [7:0] devfn;
            logic       unused_hi;

            assign devfn     = cfg_i[15:8];
            assign unused_hi = ^{cfg_i[31:16], cfg_i[1:0]};

            always_comb begin
                word_o            = cfg_i & LOWREG_MSK;
                word_o[10:8]      = devfn[2:0];
                word_o[devfn[7:3]] = 1'b1;
            end
        end else begin : g_simple
            always_comb begin
                word_o         = cfg_i;
                word_o[0]      = 1'b1;
                word_o[EN_BIT] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
    import cax_pkg::*;
#(
    parameter bit          MAIN_MODE  = 1'b1,
    parameter bit          BIG_ENDIAN = 1'b0,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BASE_WORD  = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    input  logic              reg_we_i,
    output logic [31:0]       reg_rdata_o,
    output logic [31:0]       cfg_addr_o
);
    localparam int unsigned SEL_W = ADDR_W - 2;
    localparam logic [SEL_W-1:0] BASE_SEL = BASE_WORD[SEL_W-1:0];

    logic      addr_hit;
    logic      wr_hit;
    logic      unused_lane;
    cax_word_t wr_word;
    cax_word_t wr_cfg;
    cax_word_t cfg_q;
    cax_word_t rd_word;
    cax_word_t rd_bus;

    // Byte-lane bits are ignored: every access size is a full-word access.
    assign addr_hit    = (reg_addr_i[ADDR_W-1:2] == BASE_SEL);
    assign unused_lane = ^reg_addr_i[1:0];
    assign wr_hit      = addr_hit & reg_we_i;

    cax_lane_swap #(.SWAP(BIG_ENDIAN)) u_swap_in (
        .word_i (reg_wdata_i),
        .word_o (wr_word)
    );

    cax_wr_xlate #(.MAIN_MODE(MAIN_MODE)) u_wr (
        .word_i (wr_word),
        .cfg_o  (wr_cfg)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (wr_hit) begin
            cfg_q <= wr_cfg;
        end
    end

    cax_rd_xlate #(.MAIN_MODE(MAIN_MODE)) u_rd (
        .cfg_i  (cfg_q),
        .word_o (rd_word)
    );

    cax_lane_swap #(.SWAP(BIG_ENDIAN)) u_swap_out (
        .word_i (rd_word),
        .word_o (rd_bus)
    );

    assign reg_rdata_o = addr_hit ? rd_bus : '0;
    assign cfg_addr_o  = cfg_q;
endmodule

// File: rtl/cax_checker.sv
module cax_checker #(
    parameter bit MAIN_MODE = 1'b1
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        addr_hit,
    input logic        wr_hit,
    input logic [31:0] wr_word,
    input logic [31:0] rd_word,
    input logic [31:0] reg_rdata_o,
    input logic [31:0] cfg_addr_o
);
    logic unused_chk;
    assign unused_chk = ^{wr_word, rd_word};

    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (cfg_addr_o == 32'h0));

    assert_miss_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !addr_hit |-> (reg_rdata_o == 32'h0));

    assert_miss_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_hit |=> $stable(cfg_addr_o));

    generate
        if (MAIN_MODE) begin : g_main
            assert_enable_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_hit |=> cfg_addr_o[31]);
            assert_regno_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_hit |=> (cfg_addr_o[10:2] == $past(wr_word[10:2])));
            assert_zero_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_hit |=> (cfg_addr_o[30:17] == 14'h0 && cfg_addr_o[1:0] == 2'b00));
            assert_bus_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_hit |=> (cfg_addr_o[16] == $past(wr_word[0])));
            assert_no_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (wr_hit && wr_word[31:11] == 21'h0) |=> (cfg_addr_o[15:11] == 5'd0));
            assert_onehot_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (cfg_addr_o[15:11] >= 5'd11) |-> ($countones(rd_word[31:11]) == 1));
        end else begin : g_simple
            assert_flag_swap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_hit |=> (cfg_addr_o[31] && !cfg_addr_o[0]));
            assert_body_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_hit |=> (cfg_addr_o[30:1] == $past(wr_word[30:1])));
            assert_read_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                1'b1 |-> (rd_word[0] && !rd_word[31]));
        end
    endgenerate
endmodule

bind cfg_addr_xlate cax_checker #(.MAIN_MODE(MAIN_MODE)) u_cax_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_hit    (addr_hit),
    .wr_hit      (wr_hit),
    .wr_word     (wr_word),
    .rd_word     (rd_word),
    .reg_rdata_o (reg_rdata_o),
    .cfg_addr_o  (cfg_addr_o)
);

// File: tb/cfg_addr_xlate_tb_top.sv
module cfg_addr_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] rd_i, cfg_i, rd_s, cfg_s, rd_b, cfg_b;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          src;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    logic [31:0] m_i = '0, m_s = '0, m_b = '0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cfg_addr_xlate #(.MAIN_MODE(1'b1), .BIG_ENDIAN(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(bus_addr), .reg_wdata_i(bus_wdata),
        .reg_we_i(bus_we), .reg_rdata_o(rd_i), .cfg_addr_o(cfg_i));
    cfg_addr_xlate #(.MAIN_MODE(1'b0), .BIG_ENDIAN(1'b0)) dut_s (
        .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(bus_addr), .reg_wdata_i(bus_wdata),
        .reg_we_i(bus_we), .reg_rdata_o(rd_s), .cfg_addr_o(cfg_s));
    cfg_addr_xlate #(.MAIN_MODE(1'b1), .BIG_ENDIAN(1'b1)) dut_b (
        .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(bus_addr), .reg_wdata_i(bus_wdata),
        .reg_we_i(bus_we), .reg_rdata_o(rd_b), .cfg_addr_o(cfg_b));

    // Reference translations written from the requirements.
    function automatic logic [31:0] ref_rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] ref_main_wr(input logic [31:0] w);
        int idx = 32;
        for (int b = 31; b >= 11; b--) if (w[b]) idx = b;
        return 32'h8000_0000 | (w[0] ? 32'h0001_0000 : 32'h0) | (w & 32'h7FC)
               | ((idx % 32) << 11);
    endfunction

    function automatic logic [31:0] ref_main_rd(input logic [31:0] s);
        int dev = (s >> 11) & 31;
        return (32'h1 << dev) | (s & 32'h700) | (s & 32'hFC);
    endfunction

    function automatic logic [31:0] ref_simp_wr(input logic [31:0] w);
        return (w & 32'hFFFF_FFFE) | 32'h8000_0000;
    endfunction

    function automatic logic [31:0] ref_simp_rd(input logic [31:0] s);
        return (s | 32'h1) & 32'h7FFF_FFFF;
    endfunction

    function automatic logic [31:0] actual(input int src);
        case (src)
            0: return rd_i;
            1: return cfg_i;
            2: return rd_s;
            3: return cfg_s;
            4: return rd_b;
            default: return cfg_b;
        endcase
    endfunction

    task automatic push(input int due, input int src, input logic [31:0] exp, input string req);
        item_t it;
        it.due = due; it.src = src; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    // Driver: one bus cycle, expectations pushed to the scoreboard.
    task automatic access(input logic [11:0] a, input logic [31:0] w, input logic we,
                          input string req);
        logic hit;
        @(posedge clk);
        #1;
        bus_addr = a; bus_wdata = w; bus_we = we;
        hit = (a[11:2] == 10'd0);
        push(cyc, 0, hit ? ref_main_rd(m_i) : 32'h0, req);
        push(cyc, 2, hit ? ref_simp_rd(m_s) : 32'h0, hit ? "R8" : "R2");
        push(cyc, 4, hit ? ref_rev(ref_main_rd(m_b)) : 32'h0, hit ? "R9" : "R2");
        if (we && hit) begin
            m_i = ref_main_wr(w);
            m_s = ref_simp_wr(w);
            m_b = ref_main_wr(ref_rev(w));
        end
        push(cyc + 1, 1, m_i, req);
        push(cyc + 1, 3, m_s, "R7");
        push(cyc + 1, 5, m_b, "R9");
    endtask

    // Monitor: compares due items at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            logic [31:0] act;
            act = actual(sb_q[0].src);
            checks++;
            if (act !== sb_q[0].exp) begin
                failures++;
                $display("FAIL %s src=%0d cycle=%0d actual=%08h expected=%08h",
                         sb_q[0].req, sb_q[0].src, cyc, act, sb_q[0].exp);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state read back through the window
        access(12'h000, 32'h0, 1'b0, "R1");
        // R3/R5: several select bits, lowest wins; bit 0 picks bus encoding
        access(12'h000, 32'h8004_2001, 1'b1, "R3");
        access(12'h000, 32'h0, 1'b0, "R5");
        // R3: no select bit set, device field wraps to 0
        access(12'h000, 32'h0000_07FD, 1'b1, "R3");
        access(12'h000, 32'h0, 1'b0, "R6");
        // R4: junk everywhere, bit 1 and high bits must not leak
        access(12'h000, 32'hFFFF_FFFE, 1'b1, "R4");
        access(12'h000, 32'h0, 1'b0, "R4");
        // R11/R2: write outside the window, then read outside
        access(12'h010, 32'h0040_0000, 1'b1, "R11");
        access(12'h004, 32'h0, 1'b0, "R2");
        access(12'h000, 32'h0, 1'b0, "R11");
        // R2: byte-lane address bits ignored
        access(12'h003, 32'h0002_0A04, 1'b1, "R2");
        access(12'h002, 32'h0, 1'b0, "R2");
        // R10: back-to-back writes, each cycle reads the prior value
        access(12'h000, 32'h0010_0300, 1'b1, "R10");
        access(12'h000, 32'h4000_0540, 1'b1, "R10");
        access(12'h000, 32'h0, 1'b0, "R10");
        // R6: round trip for every device 11..31 and every function
        for (int d = 11; d <= 31; d++) begin
            for (int f = 0; f < 8; f++) begin
                logic [31:0] w;
                w = (32'h1 << d) | (32'(f) << 8) | (32'((d * 7 + f) % 64) << 2);
                access(12'h000, w, 1'b1, "R6");
                access(12'h000, 32'h0, 1'b0, "R6");
            end
        end
        // R7/R8/R9: patterns aimed at the simple and swapped variants
        access(12'h000, 32'h0000_0B80, 1'b1, "R9");
        access(12'h000, 32'h0, 1'b0, "R9");
        access(12'h000, 32'h7FFF_FFFF, 1'b1, "R7");
        access(12'h000, 32'h0, 1'b0, "R8");
        repeat (4) @(posedge clk);
        #1;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule